// File: doc/BRIEF.md
# BCD Calendar Clock Register Bank

This block keeps wall-clock time and calendar date as packed BCD counts in eight byte-wide registers. A prescaled `tick` input, arriving `TICKS_PER_SEC` times per second, drives an internal sub-second counter. Each completed second advances seconds, minutes, hours, day of week, date, month and year with calendar-correct rollover. A century flag in the hours byte inverts at the year wrap when its enable flag is set. A stop flag in the seconds byte freezes timekeeping and drops the oscillator-enable output. Clearing the stop flag after it was set produces a one-cycle kick-start pulse.

A host reads or writes the registers through a plain register port: a 3-bit address, write data, a one-cycle write strobe, and a level read-active signal with combinational read data. The port has no valid/ready handshake because it never stalls. Writes take effect at the next clock edge, and reads return data in the same cycle. While a read of one of the seven time registers is active, due one-second updates are held back so that a multi-byte read sees one consistent snapshot. The hold lasts at most `HOLD_TICKS` ticks, after which the update is forced. Seconds that fall due during a hold are queued and applied later, so none is lost. A read of the control byte never holds updates.

Top module: `rtc_regbank`

## Requirements
- R1: After reset, addresses 0..7 read 0x00, 0x00, 0x00, 0x01, 0x01, 0x01, 0x00, 0x00. `osc_en` is 1 and `kick` is 0.
- R2: The address map is: 0 seconds, 1 minutes, 2 hours, 3 day of week (bits 2:0, 1..7), 4 date, 5 month, 6 two-digit year, 7 control. Time and date fields are packed BCD, tens digit above units digit. The control byte stores and returns all 8 bits.
- R3: Every `TICKS_PER_SEC` ticks while running, the time advances by one second. Seconds 59 wrap to 00 and carry into minutes. Minutes 59 wrap to 00 and carry into hours. Hours 23 wrap to 00 and carry into the day.
- R4: On a day carry, day of week counts up and wraps from 7 to 1.
- R5: The date wraps to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months except February. February ends at 29 when the year value is divisible by 4, and at 28 otherwise.
- R6: On a carry past the last day, the month counts up and wraps from 12 to 01. A wrap of month 12 advances the year, and year 99 wraps to 00.
- R7: Bit 7 of address 0 is the stop flag and reads back as written. While it is 1, `osc_en` is 0 and ticks advance no count.
- R8: A write to address 0 that clears the stop flag while it is 1 gives `kick` high for exactly one cycle after the write edge. No other write pulses `kick`.
- R9: While `host_rd` is 1 and `host_addr` is 0..6, a second that falls due does not change the registers. The update is forced once `HOLD_TICKS` further ticks have arrived. Any update still pending is applied after the read ends, and no second is lost.
- R10: While `host_rd` is 1 with `host_addr` 7, second updates are applied without delay.
- R11: Address 2 holds the century-enable flag in bit 7 and the century flag in bit 6, with the hours in bits 5:0. The century flag inverts at the year 99 to 00 wrap only when the enable flag is 1.
- R12: Unused bits read as 0 and ignore writes: address 1 bit 7, address 3 bits 7:3, address 4 bits 7:6, and address 5 bits 7:5.
- R13: A write to address 0 restarts the sub-second phase. The next second then completes after a full `TICKS_PER_SEC` ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Sub-second pulse, `TICKS_PER_SEC` per second |
| host_addr | input | 3 | Register address |
| host_wdata | input | 8 | Write data |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_rd | input | 1 | Read active; holds updates for addresses 0..6 |
| host_rdata | output | 8 | Read data for `host_addr`, combinational |
| osc_en | output | 1 | Oscillator enable, low while stopped |
| kick | output | 1 | One-cycle kick-start pulse on restart |

## Verification
A wrong carry or month-length decision shows up in the register readback at the first second boundary that crosses it. The bench therefore runs random start times biased toward the wrap points and compares all seven time registers after each short advance. A fault in the sub-second or pending-update state shows as a second that lands one update early or late, or as a lost second. The hold test and the phase-restart test catch this within one second of ticks. A stuck stop or kick state shows up on `osc_en` or `kick` in the cycle after the write.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] min;
    logic [5:0] hr;
    logic [2:0] dow;
    logic [5:0] date;
    logic [4:0] mon;
    logic [7:0] yr;
    logic       cb;
  } rtc_time_t;

  localparam rtc_time_t TIME_RESET = '{
    sec: 7'h00, min: 7'h00, hr: 6'h00, dow: 3'd1,
    date: 6'h01, mon: 5'h01, yr: 8'h00, cb: 1'b0};

  // Two-digit BCD increment; units 9 carries into the tens digit.
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // Year divisible by four: (10t+u) mod 4 equals (2t+u) mod 4.
  function automatic logic is_leap(input logic [7:0] yr);
    logic [4:0] s;
    s = {yr[7:4], 1'b0} + {1'b0, yr[3:0]};
    return (s[1:0] == 2'b00);
  endfunction

  function automatic logic [5:0] last_day(input logic [4:0] mon, input logic [7:0] yr);
    logic [5:0] d;
    case (mon)
      5'h02:                      d = is_leap(yr) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: d = 6'h30;
      default:                    d = 6'h31;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/rtc_tick_ctrl.sv
module rtc_tick_ctrl #(
  parameter int TICKS_PER_SEC = 8,
  parameter int HOLD_TICKS    = 2,
  parameter int PEND_W        = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  input  logic phase_clr,
  input  logic rd_hold,
  input  logic wr_busy,
  output logic apply,
  output logic hold_full
);
  localparam int SW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam int HW = $clog2(HOLD_TICKS + 1);
  localparam logic [SW-1:0]     SUB_LAST  = SW'(TICKS_PER_SEC - 1);
  localparam logic [HW-1:0]     HOLD_LAST = HW'(HOLD_TICKS);
  localparam logic [PEND_W-1:0] PEND_MAX  = '1;

  logic [SW-1:0]     sub_q;
  logic [HW-1:0]     hold_q;
  logic [PEND_W-1:0] pend_q;
  logic              sec_due;

  assign sec_due   = tick && run && (sub_q == SUB_LAST);
  assign hold_full = (hold_q == HOLD_LAST);
  assign apply     = (pend_q != '0) && !wr_busy && (!rd_hold || hold_full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q <= '0;
    end else if (phase_clr) begin
      sub_q <= '0;
    end else if (tick && run) begin
      sub_q <= sec_due ? '0 : sub_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (phase_clr) begin
      pend_q <= '0;
    end else begin
      case ({sec_due, apply})
        2'b10:   if (pend_q != PEND_MAX) pend_q <= pend_q + 1'b1;
        2'b01:   pend_q <= pend_q - 1'b1;
        default: pend_q <= pend_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (phase_clr || apply || pend_q == '0) begin
      hold_q <= '0;
    end else if (rd_hold && tick && !hold_full) begin
      hold_q <= hold_q + 1'b1;
    end
  end

endmodule

// File: rtl/rtc_calendar_next.sv
module rtc_calendar_next
  import rtc_pkg::*;
(
  input  rtc_time_t cur,
  input  logic      ceb,
  output rtc_time_t nxt
);
  logic sec_wrap, min_wrap, hr_wrap, date_wrap, mon_wrap, yr_wrap;
  logic [7:0] sec_i, min_i, hr_i, date_i, mon_i, yr_i;

  assign sec_wrap  = cur.sec  >= 7'h59;
  assign min_wrap  = cur.min  >= 7'h59;
  assign hr_wrap   = cur.hr   >= 6'h23;
  assign date_wrap = cur.date >= last_day(cur.mon, cur.yr);
  assign mon_wrap  = cur.mon  >= 5'h12;
  assign yr_wrap   = cur.yr   >= 8'h99;

  assign sec_i  = bcd_inc({1'b0, cur.sec});
  assign min_i  = bcd_inc({1'b0, cur.min});
  assign hr_i   = bcd_inc({2'b00, cur.hr});
  assign date_i = bcd_inc({2'b00, cur.date});
  assign mon_i  = bcd_inc({3'b000, cur.mon});
  assign yr_i   = bcd_inc(cur.yr);

  always_comb begin
    nxt     = cur;
    nxt.sec = sec_wrap ? 7'h00 : sec_i[6:0];
    if (sec_wrap) begin
      nxt.min = min_wrap ? 7'h00 : min_i[6:0];
      if (min_wrap) begin
        nxt.hr = hr_wrap ? 6'h00 : hr_i[5:0];
        if (hr_wrap) begin
          nxt.dow  = (cur.dow >= 3'd7) ? 3'd1 : cur.dow + 3'd1;
          nxt.date = date_wrap ? 6'h01 : date_i[5:0];
          if (date_wrap) begin
            nxt.mon = mon_wrap ? 5'h01 : mon_i[4:0];
            if (mon_wrap) begin
              nxt.yr = yr_wrap ? 8'h00 : yr_i;
              if (yr_wrap && ceb) nxt.cb = ~cur.cb;
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/rtc_regbank.sv
module rtc_regbank
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 8,
  parameter int HOLD_TICKS    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [2:0] host_addr,
  input  logic [7:0] host_wdata,
  input  logic       host_wr,
  input  logic       host_rd,
  output logic [7:0] host_rdata,
  output logic       osc_en,
  output logic       kick
);
  localparam logic [2:0] A_SEC  = 3'd0;
  localparam logic [2:0] A_MIN  = 3'd1;
  localparam logic [2:0] A_HR   = 3'd2;
  localparam logic [2:0] A_DOW  = 3'd3;
  localparam logic [2:0] A_DATE = 3'd4;
  localparam logic [2:0] A_MON  = 3'd5;
  localparam logic [2:0] A_YR   = 3'd6;
  localparam logic [2:0] A_CTRL = 3'd7;

  rtc_time_t  time_q, time_nxt;
  logic       ceb_q, stop_q, kick_q;
  logic [7:0] ctrl_q;
  logic       rd_hold, apply, hold_full, sec_wr;

  assign rd_hold = host_rd && (host_addr != A_CTRL);
  assign sec_wr  = host_wr && (host_addr == A_SEC);

  rtc_tick_ctrl #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .HOLD_TICKS   (HOLD_TICKS),
    .PEND_W       (2)
  ) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .run      (!stop_q),
    .phase_clr(sec_wr),
    .rd_hold  (rd_hold),
    .wr_busy  (host_wr),
    .apply    (apply),
    .hold_full(hold_full)
  );

  rtc_calendar_next u_next (
    .cur(time_q),
    .ceb(ceb_q),
    .nxt(time_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q <= TIME_RESET;
      ceb_q  <= 1'b0;
      stop_q <= 1'b0;
      ctrl_q <= 8'h00;
      kick_q <= 1'b0;
    end else begin
      kick_q <= sec_wr && stop_q && !host_wdata[7];
      if (apply) time_q <= time_nxt;
      if (host_wr) begin
        case (host_addr)
          A_SEC:  begin stop_q <= host_wdata[7]; time_q.sec <= host_wdata[6:0]; end
          A_MIN:  time_q.min <= host_wdata[6:0];
          A_HR:   begin
                    ceb_q     <= host_wdata[7];
                    time_q.cb <= host_wdata[6];
                    time_q.hr <= host_wdata[5:0];
                  end
          A_DOW:  time_q.dow  <= host_wdata[2:0];
          A_DATE: time_q.date <= host_wdata[5:0];
          A_MON:  time_q.mon  <= host_wdata[4:0];
          A_YR:   time_q.yr   <= host_wdata;
          default: ctrl_q <= host_wdata;
        endcase
      end
    end
  end

  always_comb begin
    case (host_addr)
      A_SEC:   host_rdata = {stop_q, time_q.sec};
      A_MIN:   host_rdata = {1'b0, time_q.min};
      A_HR:    host_rdata = {ceb_q, time_q.cb, time_q.hr};
      A_DOW:   host_rdata = {5'b0, time_q.dow};
      A_DATE:  host_rdata = {2'b0, time_q.date};
      A_MON:   host_rdata = {3'b0, time_q.mon};
      A_YR:    host_rdata = time_q.yr;
      default: host_rdata = ctrl_q;
    endcase
  end

  assign osc_en = !stop_q;
  assign kick   = kick_q;

endmodule

// File: rtl/rtc_regbank_chk.sv
module rtc_regbank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] host_addr,
  input logic [7:0] host_wdata,
  input logic       host_wr,
  input logic [7:0] host_rdata,
  input logic       osc_en,
  input logic       kick,
  input logic       rd_hold,
  input logic       apply,
  input logic       hold_full,
  input logic [6:0] sec_cnt
);
  // R7: a write that sets the stop flag drops the oscillator enable.
  a_r7_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_addr == 3'd0 && host_wdata[7] |=> !osc_en);

  // R8: kick only accompanies a stopped-to-running transition.
  a_r8_kick_edge: assert property (@(posedge clk) disable iff (!rst_n)
    kick |-> osc_en && !$past(osc_en));

  // R8: kick lasts a single cycle.
  a_r8_kick_single: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !kick);

  // R9: an unexpired hold on a time read keeps the read data steady.
  a_r9_read_stable: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hold && $past(rd_hold) && $stable(host_addr) && !$past(host_wr)
      && !$past(hold_full) |-> $stable(host_rdata));

  // R3: an applied update at second 59 lands on second 00.
  a_r3_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $past(apply) && $past(sec_cnt) == 7'h59 |-> sec_cnt == 7'h00);
endmodule

bind rtc_regbank rtc_regbank_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .host_addr (host_addr),
  .host_wdata(host_wdata),
  .host_wr   (host_wr),
  .host_rdata(host_rdata),
  .osc_en    (osc_en),
  .kick      (kick),
  .rd_hold   (rd_hold),
  .apply     (apply),
  .hold_full (hold_full),
  .sec_cnt   (time_q.sec)
);

// File: tb/tb_rtc_regbank.sv
module tb_rtc_regbank;
  localparam int TPS  = 8;
  localparam int HOLD = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [2:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic       host_wr = 1'b0;
  logic       host_rd = 1'b0;
  logic [7:0] host_rdata;
  logic       osc_en, kick;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench model of the time, in binary
  int ms, mm, mh, mdw, md, mmo, my, mcb, mceb, mstop;

  rtc_regbank #(.TICKS_PER_SEC(TPS), .HOLD_TICKS(HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_wr(host_wr), .host_rd(host_rd),
    .host_rdata(host_rdata), .osc_en(osc_en), .kick(kick));

  always #5 clk = ~clk;

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int days_in(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_step();
    ms++;
    if (ms == 60) begin
      ms = 0; mm++;
      if (mm == 60) begin
        mm = 0; mh++;
        if (mh == 24) begin
          mh = 0;
          mdw = (mdw == 7) ? 1 : mdw + 1;
          md++;
          if (md > days_in(mmo, my)) begin
            md = 1; mmo++;
            if (mmo == 13) begin
              mmo = 1; my++;
              if (my == 100) begin
                my = 0;
                if (mceb == 1) mcb = 1 - mcb;
              end
            end
          end
        end
      end
    end
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    host_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic set_time(input int h, input int mi, input int s, input int dw,
                          input int d, input int mo, input int y,
                          input int ceb, input int cb);
    mh = h; mm = mi; ms = s; mdw = dw; md = d; mmo = mo; my = y;
    mceb = ceb; mcb = cb; mstop = 0;
    wr(3'd1, bcd(mi));
    wr(3'd2, {ceb[0], cb[0], bcd(h)[5:0]});
    wr(3'd3, 8'(dw));
    wr(3'd4, bcd(d));
    wr(3'd5, bcd(mo));
    wr(3'd6, bcd(y));
    wr(3'd0, bcd(s));
  endtask

  task automatic compare_all(input string req);
    logic [7:0] v;
    rd(3'd0, v); chk({req, " sec"},  v, {mstop[0], bcd(ms)[6:0]});
    rd(3'd1, v); chk({req, " min"},  v, bcd(mm));
    rd(3'd2, v); chk({req, " hour"}, v, {mceb[0], mcb[0], bcd(mh)[5:0]});
    rd(3'd3, v); chk({req, " dow"},  v, 8'(mdw));
    rd(3'd4, v); chk({req, " date"}, v, bcd(md));
    rd(3'd5, v); chk({req, " mon"},  v, bcd(mmo));
    rd(3'd6, v); chk({req, " year"}, v, bcd(my));
  endtask

  task automatic advance(input int secs);
    ticks(secs * TPS);
    for (int i = 0; i < secs; i++) model_step();
  endtask

  initial begin
    logic [7:0] v;
    void'($urandom(32'd20240229));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, v); chk("R1 sec", v, 8'h00);
    rd(3'd1, v); chk("R1 min", v, 8'h00);
    rd(3'd2, v); chk("R1 hour", v, 8'h00);
    rd(3'd3, v); chk("R1 dow", v, 8'h01);
    rd(3'd4, v); chk("R1 date", v, 8'h01);
    rd(3'd5, v); chk("R1 mon", v, 8'h01);
    rd(3'd6, v); chk("R1 year", v, 8'h00);
    rd(3'd7, v); chk("R1 ctrl", v, 8'h00);
    chk("R1 osc_en", {7'b0, osc_en}, 8'h01);
    chk("R1 kick", {7'b0, kick}, 8'h00);

    // R2 control byte and map
    wr(3'd7, 8'hA5);
    rd(3'd7, v); chk("R2 ctrl", v, 8'hA5);
    set_time(12, 34, 56, 3, 17, 8, 42, 0, 0);
    compare_all("R2");

    // R3 basic second and hour wrap
    advance(1); compare_all("R3 one second");
    set_time(23, 59, 58, 7, 14, 6, 10, 0, 0);
    advance(3); compare_all("R3 R4 day wrap");

    // R5 month lengths and leap
    set_time(23, 59, 59, 2, 28, 2, 24, 0, 0);
    advance(1); compare_all("R5 leap feb");
    set_time(23, 59, 59, 2, 28, 2, 23, 0, 0);
    advance(1); compare_all("R5 plain feb");
    set_time(23, 59, 59, 4, 30, 4, 5, 0, 0);
    advance(1); compare_all("R5 april");
    set_time(23, 59, 59, 4, 29, 2, 0, 0, 0);
    advance(1); compare_all("R5 year00 leap");

    // R6 R11 year wrap with and without century enable
    set_time(23, 59, 59, 5, 31, 12, 99, 1, 0);
    advance(1); compare_all("R6 R11 century on");
    set_time(23, 59, 59, 5, 31, 12, 99, 0, 1);
    advance(1); compare_all("R11 century off");

    // R12 unused bits
    wr(3'd1, 8'hFF); rd(3'd1, v); chk("R12 min", v, 8'h7F);
    wr(3'd3, 8'hFF); rd(3'd3, v); chk("R12 dow", v, 8'h07);
    wr(3'd4, 8'hFF); rd(3'd4, v); chk("R12 date", v, 8'h3F);
    wr(3'd5, 8'hFF); rd(3'd5, v); chk("R12 mon", v, 8'h1F);

    // R7 R8 stop and kick
    set_time(10, 20, 30, 1, 1, 1, 1, 0, 0);
    wr(3'd0, 8'h80 | bcd(30)); mstop = 1;
    chk("R8 no kick on stop", {7'b0, kick}, 8'h00);
    chk("R7 osc_en low", {7'b0, osc_en}, 8'h00);
    ticks(2 * TPS);
    compare_all("R7 frozen");
    wr(3'd0, bcd(30)); mstop = 0;
    chk("R8 kick high", {7'b0, kick}, 8'h01);
    @(negedge clk);
    chk("R8 kick one cycle", {7'b0, kick}, 8'h00);
    chk("R7 osc_en back", {7'b0, osc_en}, 8'h01);
    wr(3'd0, bcd(30));
    chk("R8 no kick when running", {7'b0, kick}, 8'h00);
    advance(1); compare_all("R7 running again");

    // R13 seconds write restarts phase
    set_time(1, 2, 3, 1, 1, 1, 1, 0, 0);
    ticks(5);
    wr(3'd0, bcd(3));
    ticks(TPS - 1);
    compare_all("R13 not yet");
    ticks(1); model_step();
    compare_all("R13 full second");

    // R9 hold during a time read
    set_time(5, 6, 7, 1, 1, 1, 1, 0, 0);
    @(negedge clk); host_addr = 3'd0; host_rd = 1'b1;
    ticks(TPS);
    chk("R9 held", host_rdata, bcd(7));
    ticks(HOLD - 1);
    chk("R9 still held", host_rdata, bcd(7));
    ticks(1);
    chk("R9 forced", host_rdata, bcd(8));
    host_rd = 1'b0; model_step();
    set_time(5, 6, 7, 1, 1, 1, 1, 0, 0);
    @(negedge clk); host_addr = 3'd4; host_rd = 1'b1;
    ticks(TPS);
    host_rd = 1'b0;
    @(negedge clk); @(negedge clk);
    model_step();
    compare_all("R9 applied after read");

    // R10 control read does not hold
    set_time(5, 6, 7, 1, 1, 1, 1, 0, 0);
    @(negedge clk); host_addr = 3'd7; host_rd = 1'b1;
    ticks(TPS);
    host_rd = 1'b0; model_step();
    rd(3'd0, v); chk("R10 no hold on ctrl", v, bcd(8));

    // random starts biased toward wrap points (R3 R4 R5 R6)
    for (int it = 0; it < 30; it++) begin
      int mo, y, d, h, mi, s, n;
      mo = ($urandom % 3 == 0) ? 12 : 1 + $urandom % 12;
      y  = ($urandom % 3 == 0) ? 99 : $urandom % 100;
      d  = ($urandom % 2 == 0) ? days_in(mo, y) : 1 + $urandom % days_in(mo, y);
      h  = ($urandom % 2 == 0) ? 23 : $urandom % 24;
      mi = ($urandom % 2 == 0) ? 59 : $urandom % 60;
      s  = 50 + $urandom % 10;
      set_time(h, mi, s, 1 + $urandom % 7, d, mo, y, $urandom % 2, $urandom % 2);
      n = 1 + $urandom % 12;
      advance(n);
      compare_all("R3 R4 R5 R6 random");
    end

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule